// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block acts as a bus initiator that hands one command to a firmware-style mailbox target and waits for its answer. A request carries an 8-bit message code and a 32-bit argument. The argument can also be given as a frequency in kHz, which the block turns into whole MHz, rounding up. The block then writes three mailbox registers in a fixed order. It clears the reply register, loads the argument register, and writes the message register, which is the write that triggers the target.

After the trigger, the block reads the reply register until the value is non-zero. Between reads it waits an interval that is programmed in microseconds and timed from a clock-frequency parameter. It gives up after a programmed number of retries. It then reads the argument register once more to get the value the target actually granted, and returns that value in MHz and in kHz together with the reply code. When a display-clock command completes and the granted value differs from a stored bypass value, the block also emits a derived loop count with a strobe.

Top module: `mbox_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, timeout, loop_upd and bus_req are all 0.
- R2: When start is seen in idle, busy is 1 from the next cycle. The block then makes exactly three writes in this order: data 0 to BASE+0x29B (reply), the argument to BASE+0x293, and the message code, zero-extended, to BASE+0x283. It never drives any address other than these three.
- R3: With in_khz=1, the argument written is ceil(param/1000). With in_khz=0, param is written unchanged.
- R4: Once bus_req is raised, it stays high with bus_addr, bus_we and bus_wdata unchanged until the cycle in which bus_ack is 1.
- R5: Reply reads go on while the value read is 0 (busy). The first non-zero value ends polling and appears on status. Consecutive reply reads complete poll_us*CLK_MHZ+2 cycles apart.
- R6: If retry_lim+1 reply reads all return 0, the block sets timeout=1 with status=0, then finishes the command normally.
- R7: After polling, the argument register is read once. Its value appears on granted, and granted_khz equals granted*1000 (modulo 2^32).
- R8: done is a one-cycle pulse. busy is 0 in the cycle done is 1, and all results are valid in that cycle.
- R9: For message code 0x04, when there is no timeout and granted differs from bypass_mhz, loop_upd pulses together with done and loop_cnt=granted/7. In every other case loop_upd stays 0.
- R10: A start that arrives while busy is ignored. It causes no extra mailbox write, and it leaves the results of the running command unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (used only when idle) |
| in_khz | input | 1 | param is a kHz frequency to be rounded up to MHz |
| msg_id | input | 8 | Message code |
| param | input | 32 | Argument, or frequency in kHz |
| poll_us | input | 16 | Wait between reply reads, in microseconds (1 or more) |
| retry_lim | input | 16 | Extra reply reads allowed after the first |
| bypass_mhz | input | 32 | Stored bypass value compared with the granted value |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Last command ran out of retries |
| status | output | 32 | Last reply value read |
| granted | output | 32 | Granted value, in MHz |
| granted_khz | output | 32 | Granted value times 1000 |
| loop_cnt | output | 32 | Granted value divided by 7 |
| loop_upd | output | 1 | loop_cnt update strobe |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; bus_rdata is valid |
| bus_rdata | input | 32 | Read data |

## Verification
The assertions assume that the target acknowledges only while bus_req is high, at most once per access, and that reset starts the block in idle. The bench target model meets these conditions. Its acknowledge is registered, so it can never fall in two consecutive cycles or arrive without a request. It answers only after a chosen number of busy reads, and it changes the argument register only once it has answered. The bench drives start only at clock low and holds poll_us at 1 or more.

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq #(
  parameter int          CLK_MHZ  = 100,
  parameter int          AW       = 32,
  parameter logic [31:0] BASE     = 32'h0001_6000,
  parameter logic [31:0] OFS_RSP  = 32'h29B,
  parameter logic [31:0] OFS_ARG  = 32'h293,
  parameter logic [31:0] OFS_MSG  = 32'h283,
  parameter logic [7:0]  MSG_DISP = 8'h04,
  parameter int          LOOP_DIV = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_khz,
  input  logic [7:0]    msg_id,
  input  logic [31:0]   param,
  input  logic [15:0]   poll_us,
  input  logic [15:0]   retry_lim,
  input  logic [31:0]   bypass_mhz,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [31:0]   status,
  output logic [31:0]   granted,
  output logic [31:0]   granted_khz,
  output logic [31:0]   loop_cnt,
  output logic          loop_upd,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [31:0]   bus_rdata
);
  localparam logic [31:0] A_RSP = BASE + OFS_RSP;
  localparam logic [31:0] A_ARG = BASE + OFS_ARG;
  localparam logic [31:0] A_MSG = BASE + OFS_MSG;

  typedef enum logic [2:0] {S_IDLE, S_WRSP, S_WARG, S_WMSG, S_RRSP, S_WAIT, S_RARG} st_t;
  st_t st;

  logic [7:0]  msg_q;
  logic [31:0] arg_q, tmr;
  logic [15:0] rcnt;

  logic [32:0] khz_up;
  logic [31:0] mhz_conv, ivl;
  assign khz_up   = {1'b0, param} + 33'd999;
  assign mhz_conv = 32'(khz_up / 33'd1000);
  assign ivl      = 32'(poll_us) * 32'(CLK_MHZ);

  assign busy        = (st != S_IDLE);
  assign granted_khz = granted * 32'd1000;
  assign bus_req     = (st == S_WRSP) || (st == S_WARG) || (st == S_WMSG) ||
                       (st == S_RRSP) || (st == S_RARG);
  assign bus_we      = (st == S_WRSP) || (st == S_WARG) || (st == S_WMSG);

  always_comb begin
    bus_addr  = AW'(A_RSP);
    bus_wdata = 32'd0;
    case (st)
      S_WARG: begin bus_addr = AW'(A_ARG); bus_wdata = arg_q; end
      S_WMSG: begin bus_addr = AW'(A_MSG); bus_wdata = {24'd0, msg_q}; end
      S_RARG: bus_addr = AW'(A_ARG);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      msg_q    <= '0;
      arg_q    <= '0;
      tmr      <= '0;
      rcnt     <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      status   <= '0;
      granted  <= '0;
      loop_cnt <= '0;
      loop_upd <= 1'b0;
    end else begin
      done     <= 1'b0;
      loop_upd <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          msg_q   <= msg_id;
          arg_q   <= in_khz ? mhz_conv : param;
          timeout <= 1'b0;
          rcnt    <= '0;
          st      <= S_WRSP;
        end
        S_WRSP: if (bus_ack) st <= S_WARG;
        S_WARG: if (bus_ack) st <= S_WMSG;
        S_WMSG: if (bus_ack) st <= S_RRSP;
        S_RRSP: if (bus_ack) begin
          status <= bus_rdata;
          if (bus_rdata != 32'd0) st <= S_RARG;
          else if (rcnt == retry_lim) begin
            timeout <= 1'b1;
            st      <= S_RARG;
          end else begin
            rcnt <= rcnt + 16'd1;
            tmr  <= '0;
            st   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (tmr + 32'd1 >= ivl) st <= S_RRSP;
          else tmr <= tmr + 32'd1;
        end
        S_RARG: if (bus_ack) begin
          granted <= bus_rdata;
          done    <= 1'b1;
          st      <= S_IDLE;
          if (msg_q == MSG_DISP && !timeout && bus_rdata != bypass_mhz) begin
            loop_cnt <= bus_rdata / 32'(LOOP_DIV);
            loop_upd <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
  parameter int          AW   = 32,
  parameter logic [31:0] BASE = 32'h0001_6000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          timeout,
  input logic [31:0]   status,
  input logic          loop_upd,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_ack
);
  localparam logic [AW-1:0] A0 = AW'(BASE + 32'h29B);
  localparam logic [AW-1:0] A1 = AW'(BASE + 32'h293);
  localparam logic [AW-1:0] A2 = AW'(BASE + 32'h283);

  // R4
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R2
  addr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr == A0 || bus_addr == A1 || bus_addr == A2));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  timeout_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && timeout |-> status == 32'd0);

  // R9
  loop_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_upd |-> done && !timeout);
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timeout(timeout), .status(status), .loop_upd(loop_upd), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/sim_mbox_cmd_seq.sv
`timescale 1ns/1ps
module sim_mbox_cmd_seq;
  localparam int CLK_MHZ = 4;
  localparam logic [31:0] BASE = 32'h0001_6000;
  localparam logic [31:0] A_RSP = BASE + 32'h29B;
  localparam logic [31:0] A_ARG = BASE + 32'h293;
  localparam logic [31:0] A_MSG = BASE + 32'h283;
  localparam logic [31:0] BYP = 32'd600;
  localparam int POLL = 2;
  localparam int NV = 6;

  // {in_khz, msg, param, reply code, busy reads before reply, grant offset, expected arg written}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 8'h04, 32'd300,        8'h01, 8'd0, 8'd5,  32'd300},
    {1'b1, 8'h04, 32'd600000,     8'h01, 8'd2, 8'd0,  32'd600},
    {1'b1, 8'h05, 32'd1001,       8'hFE, 8'd1, 8'd0,  32'd2},
    {1'b1, 8'h04, 32'd599999,     8'hFD, 8'd0, 8'd10, 32'd600},
    {1'b0, 8'h05, 32'hDEADBEEF,   8'hFF, 8'd3, 8'd1,  32'hDEADBEEF},
    {1'b1, 8'h04, 32'd1000,       8'hFC, 8'd0, 8'd0,  32'd1}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, in_khz = 0;
  logic [7:0] msg_id = 0;
  logic [31:0] param = 0;
  logic [15:0] poll_us = POLL[15:0], retry_lim = 16'd20;
  logic busy, done, timeout, loop_upd, bus_req, bus_we, bus_ack;
  logic [31:0] status, granted, granted_khz, loop_cnt, bus_addr, bus_wdata, bus_rdata;

  always #4 clk = ~clk;

  mbox_cmd_seq #(.CLK_MHZ(CLK_MHZ), .AW(32), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_khz(in_khz), .msg_id(msg_id),
    .param(param), .poll_us(poll_us), .retry_lim(retry_lim), .bypass_mhz(BYP),
    .busy(busy), .done(done), .timeout(timeout), .status(status), .granted(granted),
    .granted_khz(granted_khz), .loop_cnt(loop_cnt), .loop_upd(loop_upd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  // behavioural mailbox target
  logic [7:0]  t_code = 0, t_after = 0;
  logic [31:0] t_add = 0;
  logic [31:0] areg, wa [8], wd [8], cyc, last_ack, gap;
  logic [3:0]  wcnt, nid, nrd;
  logic        answered;
  wire ready = (t_code != 0) && (nrd >= 4'(t_after));
  assign bus_rdata = (bus_addr == A_RSP) ? (ready ? {24'd0, t_code} : 32'd0) :
                     (bus_addr == A_ARG) ? areg + (answered ? t_add : 32'd0) : 32'd0;

  always_ff @(posedge clk) begin
    cyc <= rst_n ? cyc + 1 : 0;
    if (!rst_n) begin
      bus_ack <= 0; wcnt <= 0; nid <= 0; nrd <= 0; answered <= 0; gap <= 0;
      areg <= 0; last_ack <= 0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (start && !busy) begin
        wcnt <= 0; nid <= 0; nrd <= 0; answered <= 0; gap <= 0;
      end else if (bus_req && bus_ack) begin
        if (bus_we) begin
          wa[wcnt[2:0]] <= bus_addr; wd[wcnt[2:0]] <= bus_wdata;
          if (wcnt < 7) wcnt <= wcnt + 1;
          if (bus_addr == A_ARG) areg <= bus_wdata;
          if (bus_addr == A_MSG) nid <= nid + 1;
        end else if (bus_addr == A_RSP) begin
          if (nrd != 0) gap <= cyc - last_ack;
          last_ack <= cyc;
          nrd <= nrd + 1;
          if (ready) answered <= 1;
        end
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic seen_upd;
  logic [31:0] seen_loop;

  task automatic run(input logic k, input logic [7:0] m, input logic [31:0] p);
    @(negedge clk);
    in_khz = k; msg_id = m; param = p; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", {31'd0, busy}, 1);
    while (!done) @(negedge clk);
    seen_upd = loop_upd; seen_loop = loop_cnt;
    chk("R8 busy low at done", {31'd0, busy}, 0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 loop_upd", {31'd0, loop_upd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {28'd0, busy, done, timeout, bus_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [96:0] v;
      logic [31:0] g;
      v = VEC[i];
      t_code = v[55:48]; t_after = v[47:40]; t_add = {24'd0, v[39:32]};
      run(v[96], v[95:88], v[87:56]);
      g = v[31:0] + t_add;
      chk("R2 write count", {28'd0, wcnt}, 3);
      chk("R2 first write addr", wa[0], A_RSP);
      chk("R2 first write data", wd[0], 0);
      chk("R2 second write addr", wa[1], A_ARG);
      chk("R3 argument written", wd[1], v[31:0]);
      chk("R2 third write addr", wa[2], A_MSG);
      chk("R2 message written", wd[2], {24'd0, v[95:88]});
      chk("R5 status", status, {24'd0, v[55:48]});
      chk("R5 reply reads", {28'd0, nrd}, 32'(v[47:40]) + 1);
      if (v[47:40] != 0) chk("R5 poll spacing", gap, POLL * CLK_MHZ + 2);
      chk("R6 no timeout", {31'd0, timeout}, 0);
      chk("R7 granted", granted, g);
      chk("R7 granted_khz", granted_khz, g * 32'd1000);
      if (v[95:88] == 8'h04 && g != BYP) begin
        chk("R9 loop strobe", {31'd0, seen_upd}, 1);
        chk("R9 loop value", seen_loop, g / 7);
      end else chk("R9 no loop strobe", {31'd0, seen_upd}, 0);
      @(negedge clk);
      chk("R8 done one cycle", {31'd0, done}, 0);
    end

    // R6 timeout with three retries
    t_code = 0; t_after = 0; t_add = 0; retry_lim = 3;
    run(1'b0, 8'h04, 32'd77);
    chk("R6 timeout flag", {31'd0, timeout}, 1);
    chk("R6 status busy", status, 0);
    chk("R6 reply reads", {28'd0, nrd}, 4);
    chk("R7 granted on timeout", granted, 77);
    chk("R9 no strobe on timeout", {31'd0, seen_upd}, 0);

    // R6 zero retries: single read
    retry_lim = 0;
    run(1'b0, 8'h05, 32'd9);
    chk("R6 single read", {28'd0, nrd}, 1);
    chk("R6 timeout flag zero retries", {31'd0, timeout}, 1);

    // R9 granted equal to bypass: no strobe
    retry_lim = 20; t_code = 8'h01; t_after = 0; t_add = 0;
    run(1'b0, 8'h04, BYP);
    chk("R9 equal to bypass", {31'd0, seen_upd}, 0);
    chk("R6 timeout cleared", {31'd0, timeout}, 0);

    // R10 start while busy is ignored
    t_code = 8'h01; t_after = 2; t_add = 3;
    @(negedge clk);
    in_khz = 0; msg_id = 8'h04; param = 32'd100; start = 1;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    msg_id = 8'h33; param = 32'd5; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk("R10 one message write", {28'd0, nid}, 1);
    chk("R10 write count", {28'd0, wcnt}, 3);
    chk("R10 message kept", wd[2], 32'h04);
    chk("R10 granted kept", granted, 103);
    @(negedge clk);
    chk("R10 stays idle", {31'd0, busy}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule